// File: doc/BRIEF.md
# Local Frame Receiver with Silence-Timed End of Frame

This block sits behind a UART receiver and assembles local frames from the incoming byte stream. A frame opens with a start byte (0x02). A length byte N follows, then N payload bytes, then one checksum byte. No terminator byte exists. The frame closes only when the line stays quiet for longer than an inter-character limit. That limit is counted in 10 µs ticks. It is either a fixed 10 ms, or five character times at the baud rate chosen by two select inputs.

At the close the block judges the frame. When the byte count matches the length field and the checksum matches, the block pulses an accept strobe and requests an ACK reply byte. In every other case it pulses a discard strobe, clears its stored count and requests a NAK reply byte. Payload bytes are written to a downstream buffer as they arrive. The accept and discard strobes tell that buffer to commit the frame or drop it.

Top module: `lframe_rx`

## Requirements
- R1: After reset all strobes (`frame_ok`, `frame_bad`, `buf_wr`, `reply_req`) are low, `stored_cnt` is 0 and `reply_byte` is 0x00.
- R2: While no frame is open, a received byte other than 0x02 is ignored. It opens no frame, writes nothing and produces no reply.
- R3: The silence limit in ticks is 1000 when `fixed_tmo` is 1, whatever the baud select. When `fixed_tmo` is 0 the limit follows `baud_sel`: 00 gives 1000, 01 gives 500, 10 gives 250 and 11 gives 125. The frame closes on the clock edge that samples the limit-th tick counted since the last received byte.
- R4: Every received byte of an open frame restarts the silence count. A byte and a tick in the same cycle count as a byte only.
- R5: A frame of 0x02, N, N payload bytes and a checksum equal to the 8-bit sum of N and the payload closes with a one-cycle `frame_ok` pulse. In the same cycle `reply_req` is high and `reply_byte` is ACK (0x06). All three appear one clock after the closing edge.
- R6: A frame whose checksum byte differs from that sum closes with a one-cycle `frame_bad` pulse, `reply_req` high, `reply_byte` NAK (0x15) and `stored_cnt` cleared to 0.
- R7: A frame that goes silent before its checksum byte has arrived, including one with only the start byte, is discarded as in R6.
- R8: A frame with one or more bytes after its checksum byte is discarded as in R6, even when the checksum is right.
- R9: Each payload byte appears on `buf_data` with a one-cycle `buf_wr` one clock after it is received. Start, length and checksum bytes are never written. `stored_cnt` counts the payload bytes written since the frame's start byte and holds that count after an accept.
- R10: A frame with length 0 and checksum 0x00 is accepted and writes no byte.
- R11: `frame_ok` and `frame_bad` are never high together, and each frame close produces exactly one reply request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received byte from the UART |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_byte` |
| fixed_tmo | input | 1 | 1: fixed 10 ms limit; 0: five character times |
| baud_sel | input | 2 | Baud select: 00=4800, 01=9600, 10=19200, 11=38400 |
| tick_10us | input | 1 | One-cycle pulse every 10 µs |
| frame_ok | output | 1 | Frame accepted (one-cycle pulse) |
| frame_bad | output | 1 | Frame discarded (one-cycle pulse) |
| buf_wr | output | 1 | Payload byte write strobe to the downstream buffer |
| buf_data | output | 8 | Payload byte being written |
| stored_cnt | output | 8 | Payload bytes stored for the current or last accepted frame |
| reply_req | output | 1 | Request to transmit `reply_byte` |
| reply_byte | output | 8 | ACK (0x06) or NAK (0x15) while `reply_req` is high |

## Verification
The bench checks the close cycle against the limit for each baud select and for the fixed mode. A design that counted the limit off by one tick, or that ignored the fixed-mode bit, would strobe one tick early or late, or at the wrong scale. It sends a slow frame whose gaps stay just below the limit, which catches a timer that is not restarted by each byte. It also sends frames that are short, frames with a trailing extra byte, frames with zero length and frames whose checksum wraps past 0xFF. These catch a parser that accepts on checksum alone, mishandles the N=0 path or uses a wide sum. Stray bytes sent while no frame is open must leave every output quiet.

// File: rtl/lframe_pkg.sv
package lframe_pkg;

    localparam logic [7:0] START_BYTE = 8'h02;
    localparam logic [7:0] ACK_BYTE   = 8'h06;
    localparam logic [7:0] NAK_BYTE   = 8'h15;

    typedef enum logic [2:0] {
        P_IDLE,   // waiting for the start byte
        P_LEN,    // next byte is the length field
        P_DATA,   // collecting payload
        P_CSUM,   // next byte is the checksum
        P_DONE,   // checksum seen, waiting for silence
        P_OVER    // bytes after the checksum: frame is spoiled
    } parse_st_t;

    typedef struct packed {
        parse_st_t  st;
        logic [7:0] len;
        logic [7:0] seen;
        logic [7:0] sum;
        logic       sum_ok;
        logic [7:0] stored;
        logic       ok;
        logic       bad;
        logic       wr;
        logic [7:0] wdata;
    } parse_t;

endpackage

// File: rtl/lframe_limit_sel.sv
module lframe_limit_sel #(
    parameter int TICKS_FIXED = 1000,
    parameter int TICKS_SLOW  = 1000,
    parameter int NUM_BAUD    = 4,
    parameter int CNT_W       = 10,
    localparam int SEL_W      = $clog2(NUM_BAUD)
) (
    input  logic             fixed_tmo,
    input  logic [SEL_W-1:0] baud_sel,
    output logic [CNT_W-1:0] limit
);

    logic [CNT_W-1:0] scaled [NUM_BAUD];

    // Each doubling of the baud rate halves five character times.
    for (genvar g = 0; g < NUM_BAUD; g++) begin : g_scale
        assign scaled[g] = CNT_W'(TICKS_SLOW >> g);
    end

    always_comb begin
        limit = fixed_tmo ? CNT_W'(TICKS_FIXED) : scaled[baud_sel];
    end

endmodule

// File: rtl/lframe_gap_timer.sv
module lframe_gap_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!active || restart) begin
            tmr_d.cnt = '0;
        end else if (tick && (tmr_q.cnt != '1)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        // Close on the tick that brings the quiet count up to the limit.
        expire = active && !restart && tick &&
                 (({1'b0, tmr_q.cnt} + 1'b1) >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R4: a byte inside an open frame leaves the quiet count at zero
    a_r4_byte_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (active && restart) |=> (tmr_q.cnt == '0));

endmodule

// File: rtl/lframe_parser.sv
module lframe_parser
    import lframe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_byte,
    input  logic       rx_valid,
    input  logic       expire,
    output logic       active,
    output logic       frame_ok,
    output logic       frame_bad,
    output logic       buf_wr,
    output logic [7:0] buf_data,
    output logic [7:0] stored_cnt
);

    parse_t ps_d, ps_q;

    always_comb begin
        ps_d     = ps_q;
        ps_d.ok  = 1'b0;
        ps_d.bad = 1'b0;
        ps_d.wr  = 1'b0;
        if (rx_valid) begin
            unique case (ps_q.st)
                P_IDLE: begin
                    if (rx_byte == START_BYTE) begin
                        ps_d.st     = P_LEN;
                        ps_d.stored = '0;
                        ps_d.sum    = '0;
                        ps_d.seen   = '0;
                    end
                end
                P_LEN: begin
                    ps_d.len  = rx_byte;
                    ps_d.sum  = rx_byte;
                    ps_d.seen = '0;
                    ps_d.st   = (rx_byte == 8'd0) ? P_CSUM : P_DATA;
                end
                P_DATA: begin
                    ps_d.sum    = ps_q.sum + rx_byte;
                    ps_d.wr     = 1'b1;
                    ps_d.wdata  = rx_byte;
                    ps_d.stored = ps_q.stored + 8'd1;
                    ps_d.seen   = ps_q.seen + 8'd1;
                    if ((ps_q.seen + 8'd1) == ps_q.len) ps_d.st = P_CSUM;
                end
                P_CSUM: begin
                    ps_d.sum_ok = (rx_byte == ps_q.sum);
                    ps_d.st     = P_DONE;
                end
                default: begin
                    ps_d.st = P_OVER;
                end
            endcase
        end else if (expire) begin
            if (ps_q.st == P_DONE && ps_q.sum_ok) begin
                ps_d.ok = 1'b1;
            end else begin
                ps_d.bad    = 1'b1;
                ps_d.stored = '0;
            end
            ps_d.st = P_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '{st: P_IDLE, default: '0};
        else        ps_q <= ps_d;
    end

    assign active     = (ps_q.st != P_IDLE);
    assign frame_ok   = ps_q.ok;
    assign frame_bad  = ps_q.bad;
    assign buf_wr     = ps_q.wr;
    assign buf_data   = ps_q.wdata;
    assign stored_cnt = ps_q.stored;

    // R2: stray bytes between frames leave the parser idle and silent
    a_r2_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && rx_valid && rx_byte != START_BYTE) |=> (!active && !buf_wr));

    // R3: the silence limit is never reached in a cycle that carries a byte
    a_r3_close_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> !rx_valid);

    // R9: every buffer write follows a received byte
    a_r9_write_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> $past(rx_valid));

    // R6: a discarded frame leaves nothing counted as stored
    a_r6_discard_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bad |-> (stored_cnt == 8'd0));

    // R11: a close strobe lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok || frame_bad) |=> !(frame_ok || frame_bad));

endmodule

// File: rtl/lframe_rx.sv
module lframe_rx
    import lframe_pkg::*;
#(
    parameter int TICKS_FIXED = 1000,
    parameter int TICKS_SLOW  = 1000,
    localparam int NUM_BAUD   = 4,
    localparam int MAX_TICKS  = (TICKS_FIXED > TICKS_SLOW) ? TICKS_FIXED : TICKS_SLOW,
    localparam int CNT_W      = $clog2(MAX_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_byte,
    input  logic       rx_valid,
    input  logic       fixed_tmo,
    input  logic [1:0] baud_sel,
    input  logic       tick_10us,
    output logic       frame_ok,
    output logic       frame_bad,
    output logic       buf_wr,
    output logic [7:0] buf_data,
    output logic [7:0] stored_cnt,
    output logic       reply_req,
    output logic [7:0] reply_byte
);

    logic [CNT_W-1:0] limit;
    logic             active;
    logic             expire;

    lframe_limit_sel #(
        .TICKS_FIXED (TICKS_FIXED),
        .TICKS_SLOW  (TICKS_SLOW),
        .NUM_BAUD    (NUM_BAUD),
        .CNT_W       (CNT_W)
    ) limit_i (
        .fixed_tmo (fixed_tmo),
        .baud_sel  (baud_sel),
        .limit     (limit)
    );

    lframe_gap_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .restart (rx_valid),
        .tick    (tick_10us),
        .limit   (limit),
        .expire  (expire)
    );

    lframe_parser parser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .expire     (expire),
        .active     (active),
        .frame_ok   (frame_ok),
        .frame_bad  (frame_bad),
        .buf_wr     (buf_wr),
        .buf_data   (buf_data),
        .stored_cnt (stored_cnt)
    );

    always_comb begin
        reply_req  = frame_ok || frame_bad;
        reply_byte = frame_ok ? ACK_BYTE : (frame_bad ? NAK_BYTE : 8'h00);
    end

    // R5: an accepted frame is answered with ACK
    a_r5_ack_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> (reply_req && reply_byte == ACK_BYTE));

    // R6: a discarded frame is answered with NAK
    a_r6_nak_on_discard: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bad |-> (reply_req && reply_byte == NAK_BYTE));

    // R11: accept and discard never coincide
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && frame_bad));

endmodule

// File: tb/lframe_rx_tb_top.sv
`timescale 1ns/1ps
module lframe_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic       fixed_tmo = 1'b1;
    logic [1:0] baud_sel = 2'b00;
    logic       tick_10us = 1'b0;
    logic       frame_ok, frame_bad, buf_wr, reply_req;
    logic [7:0] buf_data, stored_cnt, reply_byte;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    lframe_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .fixed_tmo  (fixed_tmo),
        .baud_sel   (baud_sel),
        .tick_10us  (tick_10us),
        .frame_ok   (frame_ok),
        .frame_bad  (frame_bad),
        .buf_wr     (buf_wr),
        .buf_data   (buf_data),
        .stored_cnt (stored_cnt),
        .reply_req  (reply_req),
        .reply_byte (reply_byte)
    );

    // Tick every third clock.
    int tick_ph = 0;
    always @(posedge clk) begin
        #1;
        tick_ph   = (tick_ph + 1) % 3;
        tick_10us = (tick_ph == 0);
    end

    // ---------------- behavioural reference model ----------------
    bit         m_open = 0;
    logic [7:0] m_q[$];
    int         m_gap = 0;
    logic       e_ok = 0, e_bad = 0, e_wr = 0;
    logic [7:0] e_wdata = 0, e_stored = 0;

    function automatic int cur_limit();
        if (fixed_tmo) return 1000;
        return 1000 >> baud_sel;
    endfunction

    function automatic bit frame_good();
        int s;
        if (m_q.size() < 2) return 0;
        if (m_q.size() != int'(m_q[0]) + 2) return 0;
        s = 0;
        for (int i = 0; i <= int'(m_q[0]); i++) s = s + int'(m_q[i]);
        return (s % 256) == int'(m_q[m_q.size()-1]);
    endfunction

    always @(posedge clk) begin
        e_ok = 0; e_bad = 0; e_wr = 0;
        if (!rst_n) begin
            m_open = 0; m_q.delete(); m_gap = 0; e_stored = 0; e_wdata = 0;
        end else if (rx_valid) begin
            if (!m_open) begin
                if (rx_byte == 8'h02) begin
                    m_open = 1; m_q.delete(); m_gap = 0; e_stored = 0;
                end
            end else begin
                m_q.push_back(rx_byte);
                m_gap = 0;
                if (m_q.size() >= 2 && m_q.size() <= int'(m_q[0]) + 1) begin
                    e_wr = 1; e_wdata = rx_byte; e_stored = e_stored + 8'd1;
                end
            end
        end else if (m_open && tick_10us) begin
            m_gap++;
            if (m_gap >= cur_limit()) begin
                if (frame_good()) e_ok = 1;
                else begin e_bad = 1; e_stored = 0; end
                m_open = 0;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    int seen_ok = 0, seen_bad = 0;

    always @(negedge clk) begin
        logic [7:0] exp_reply;
        exp_reply = e_ok ? 8'h06 : (e_bad ? 8'h15 : 8'h00);
        vectors++;
        if (frame_ok) seen_ok++;
        if (frame_bad) seen_bad++;
        if (frame_ok !== e_ok || frame_bad !== e_bad) begin
            miscompares++;
            $display("FAIL %s ok/bad: actual %b/%b expected %b/%b at %0t",
                     cur_req, frame_ok, frame_bad, e_ok, e_bad, $time);
        end
        if (reply_req !== (e_ok | e_bad) || reply_byte !== exp_reply) begin
            miscompares++;
            $display("FAIL %s reply: actual %b/%h expected %b/%h at %0t",
                     cur_req, reply_req, reply_byte, e_ok | e_bad, exp_reply, $time);
        end
        if (buf_wr !== e_wr || (e_wr && buf_data !== e_wdata)) begin
            miscompares++;
            $display("FAIL R9 write: actual %b/%h expected %b/%h at %0t",
                     buf_wr, buf_data, e_wr, e_wdata, $time);
        end
        if (stored_cnt !== e_stored) begin
            miscompares++;
            $display("FAIL R9 stored_cnt: actual %0d expected %0d at %0t",
                     stored_cnt, e_stored, $time);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_seq(input logic [7:0] b[$], input int gap);
        foreach (b[i]) begin
            @(posedge clk); #1;
            rx_byte = b[i]; rx_valid = 1'b1;
            @(posedge clk); #1;
            rx_valid = 1'b0;
            repeat (gap) @(posedge clk);
        end
    endtask

    task automatic settle(input int cycles);
        repeat (cycles) @(posedge clk);
        #1;
    endtask

    // Intent check on observed strobes: exactly one close of the given kind.
    task automatic expect_close(input int ok0, input int bad0, input bit want_ok,
                                input string req);
        int dok, dbad;
        dok  = seen_ok - ok0;
        dbad = seen_bad - bad0;
        vectors++;
        if (dok != (want_ok ? 1 : 0) || dbad != (want_ok ? 0 : 1)) begin
            miscompares++;
            $display("FAIL %s close count: actual ok=%0d bad=%0d expected ok=%0d bad=%0d",
                     req, dok, dbad, want_ok ? 1 : 0, want_ok ? 0 : 1);
        end
    endtask

    task automatic run_frame(input logic [7:0] b[$], input int gap, input bit want_ok,
                             input string req);
        int ok0, bad0;
        cur_req = req;
        ok0 = seen_ok; bad0 = seen_bad;
        send_seq(b, gap);
        settle(3 * cur_limit() + 20);
        expect_close(ok0, bad0, want_ok, req);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #1_900_000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int ok0, bad0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        vectors++;
        if (frame_ok !== 0 || frame_bad !== 0 || buf_wr !== 0 || reply_req !== 0 ||
            stored_cnt !== 0 || reply_byte !== 8'h00) begin
            miscompares++;
            $display("FAIL R1 reset: actual ok=%b bad=%b wr=%b req=%b cnt=%0d reply=%h expected all 0",
                     frame_ok, frame_bad, buf_wr, reply_req, stored_cnt, reply_byte);
        end
        rst_n = 1'b1;
        settle(5);

        // R2: stray bytes between frames
        cur_req = "R2";
        ok0 = seen_ok; bad0 = seen_bad;
        send_seq('{8'h11, 8'h22, 8'h03, 8'hFF}, 2);
        settle(400);
        vectors++;
        if (seen_ok != ok0 || seen_bad != bad0 || stored_cnt !== 8'd0) begin
            miscompares++;
            $display("FAIL R2 stray: actual ok=%0d bad=%0d cnt=%0d expected none",
                     seen_ok - ok0, seen_bad - bad0, stored_cnt);
        end

        // R5 / R3: good frame, fixed 10 ms
        fixed_tmo = 1'b1; baud_sel = 2'b00;
        run_frame('{8'h02, 8'h03, 8'h10, 8'h20, 8'h30, 8'h63}, 1, 1'b1, "R5");
        vectors++;
        if (stored_cnt !== 8'd3) begin
            miscompares++;
            $display("FAIL R9 held count: actual %0d expected 3", stored_cnt);
        end

        // R6: checksum wrong, 9600 scaling
        fixed_tmo = 1'b0; baud_sel = 2'b01;
        run_frame('{8'h02, 8'h02, 8'hAA, 8'h55, 8'h00}, 0, 1'b0, "R6");
        // R5 with wrapping checksum at 9600
        run_frame('{8'h02, 8'h02, 8'hAA, 8'h55, 8'h01}, 0, 1'b1, "R5");

        // R7: short frame and lone start byte, 19200
        baud_sel = 2'b10;
        run_frame('{8'h02, 8'h04, 8'h01, 8'h02}, 3, 1'b0, "R7");
        run_frame('{8'h02}, 0, 1'b0, "R7");

        // R8: trailing extra byte, 38400
        baud_sel = 2'b11;
        run_frame('{8'h02, 8'h01, 8'h7F, 8'h80, 8'hEE}, 0, 1'b0, "R8");

        // R10: zero-length frame
        run_frame('{8'h02, 8'h00, 8'h00}, 0, 1'b1, "R10");

        // R3: fixed mode overrides the fastest baud
        fixed_tmo = 1'b1;
        run_frame('{8'h02, 8'h01, 8'hFF, 8'h00}, 0, 1'b1, "R3");

        // R4: slow frame, gaps just under the 125-tick limit
        fixed_tmo = 1'b0;
        run_frame('{8'h02, 8'h02, 8'h01, 8'h02, 8'h05}, 360, 1'b1, "R4");

        // R11: back-to-back frames each get one reply
        run_frame('{8'h02, 8'h01, 8'h09, 8'h0A}, 0, 1'b1, "R11");
        run_frame('{8'h02, 8'h01, 8'h09, 8'h0B}, 0, 1'b0, "R11");

        settle(10);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule